// File: doc/BRIEF.md
# Three-wire serial EEPROM slave model

This block is a synthesizable behavioural model of a three-wire serial memory slave. A host drives a select line, a serial clock and a serial data input; the block answers on a serial data output with a separate output-enable for tri-state modelling. After a start bit the block shifts in a two-bit opcode and an address. For writes it then shifts in a data word. It carries out read, write, erase, bulk-erase, bulk-write and write-enable/disable instructions on an internal register array.

A strap input picks the word organization: 64 words of 16 bits or 128 bytes. Writes and erases launch a self-timed program cycle, counted in system clock cycles. While that cycle runs, the block can report busy/ready on the data output. All serial inputs are assumed to be synchronous to the system clock and to stay stable for at least one system clock cycle per level. The serial clock edge is found by comparing against its value at the previous system clock edge.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the output-enable is low, the write-enable latch is clear and every stored bit is 1.
- R2: While `cs` is low the output-enable is low and the instruction logic returns to waiting for a start bit; an instruction cut short by a low `cs` has no effect on memory and starts no program cycle.
- R3: With `cs` high and no start bit yet seen, rising serial clock edges with `di`=0 change nothing; the first rising edge with `di`=1 is the start bit.
- R4: After the start bit, two opcode bits and then the address, MSB first, are sampled on rising `sclk` edges; the address has 6 bits when `org`=1 and 7 bits when `org`=0.
- R5: READ (opcode 10) drives a 0 on `dout` from the edge that takes the last address bit. Each later rising edge presents the next word bit, MSB first. After the LSB the address steps up by one, wrapping at the top of the array, and output continues.
- R6: With `org`=0 words are 8 bits wide and byte address bit 0 picks the low (0) or high (1) half of the 16-bit word at the byte address shifted right by one.
- R7: WRITE (opcode 01, followed by a data word MSB first) stores the word; ERASE (opcode 11) sets the addressed word to all ones; both are ignored and start no program cycle unless the write-enable latch is set.
- R8: With opcode 00 the two address MSBs select: 11 sets the write-enable latch, 00 clears it, 10 sets every word to all ones, 01 is followed by a data word written to every location (each gated by the latch like R7).
- R9: A write or erase starts a program cycle that lasts `PROG_CYCLES` system clock cycles and runs to the end even when `cs` drops; start bits arriving during it are ignored.
- R10: If `cs` is low at some system clock edge while a program cycle runs and is then raised, `dout` is enabled and shows 0 while busy and 1 once ready, until `cs` falls or a start bit is taken.
- R11: If `cs` stays high, or stays low, for the whole program cycle, the output-enable stays low.
- R12: Once an instruction's bit count is complete, further clock and data bits are ignored until `cs` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, high selects |
| sclk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| org | input | 1 | Organization strap: 1 = 16-bit words, 0 = 8-bit words |
| dout | output | 1 | Serial data out (read data or ready/busy) |
| dout_oe | output | 1 | Output enable for `dout` |

## Verification
A serial instruction can arrive at the very moment a program cycle is still running, so instruction decode and the program timer can meet in one cycle. The bench provokes this by lowering and raising select during a write's program cycle, then clocking a full read instruction into the busy window. It then judges on every system clock, against its own model, that no start is taken and that the output shows busy and later ready. The bench also drops select in the middle of a write's data bits while a previous state is stored, and checks that the memory holds the earlier value and no status appears.

// File: rtl/mw_pkg.sv
// Shared types for the serial EEPROM slave model.
// Assumes: opcodes are the two bits following the start bit.
package mw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HDR  = 3'd1,
        ST_RD   = 3'd2,
        ST_WD   = 3'd3,
        ST_DONE = 3'd4
    } mw_state_e;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] EXT_LOCK = 2'b00;
    localparam logic [1:0] EXT_FILL = 2'b01;
    localparam logic [1:0] EXT_WIPE = 2'b10;
    localparam logic [1:0] EXT_OPEN = 2'b11;
endpackage

// File: rtl/mw_array.sv
// Storage array: WORDS rows of DW bits, addressed as words or as half-word bytes.
// Assumes: org is static; one write request per cycle; a bulk request updates every row.
module mw_array #(
    parameter int WORDS = 64,
    parameter int DW    = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      org,
    input  logic                      wr_en,
    input  logic                      wr_all,
    input  logic [$clog2(WORDS):0]    wr_addr,
    input  logic [DW-1:0]             wr_data,
    input  logic [$clog2(WORDS):0]    rd_addr,
    output logic [DW-1:0]             rd_data
);
    localparam int AW16 = $clog2(WORDS);
    localparam int AW8  = AW16 + 1;
    localparam int BW   = DW / 2;

    logic [DW-1:0]   row_q [WORDS];
    logic [AW16-1:0] wr_row;
    logic            wr_hi;
    logic            wr_lo;
    logic [DW-1:0]   wr_word;
    logic [AW16-1:0] rd_row;
    logic [DW-1:0]   rd_word;

    // Map the write address onto a row and byte lanes.
    always_comb begin
        wr_row  = org ? wr_addr[AW16-1:0] : wr_addr[AW8-1:1];
        wr_hi   = org | wr_all | wr_addr[0];
        wr_lo   = org | wr_all | ~wr_addr[0];
        wr_word = org ? wr_data : {wr_data[BW-1:0], wr_data[BW-1:0]};
    end

    genvar g;
    generate
        for (g = 0; g < WORDS; g++) begin : g_row
            logic [DW-1:0] q;
            logic          hit;
            assign hit = wr_en & (wr_all | (wr_row == AW16'(g)));
            // Hold one row; erased (all ones) after reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '1;
                end else if (hit) begin
                    if (wr_hi) q[DW-1:BW] <= wr_word[DW-1:BW];
                    if (wr_lo) q[BW-1:0]  <= wr_word[BW-1:0];
                end
            end
            assign row_q[g] = q;
        end
    endgenerate

    // Select the read word or byte.
    always_comb begin
        rd_row  = org ? rd_addr[AW16-1:0] : rd_addr[AW8-1:1];
        rd_word = row_q[rd_row];
        if (org)
            rd_data = rd_word;
        else
            rd_data = {{BW{1'b0}}, (rd_addr[0] ? rd_word[DW-1:BW] : rd_word[BW-1:0])};
    end
endmodule

// File: rtl/mw_ptimer.sv
// Self-timed program cycle: busy for CYCLES system clocks after a start pulse.
// Assumes: start pulses arriving while busy are dropped.
module mw_ptimer #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] left_q;

    // Load on start, count down, release busy at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            left_q <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            left_q <= CW'(CYCLES - 1);
        end else if (busy) begin
            if (left_q == '0) busy <= 1'b0;
            else              left_q <= left_q - CW'(1);
        end
    end
endmodule

// File: rtl/mw_ctrl.sv
// Serial front end: start detect, header and data shifting, decode, read-out and status.
// Assumes: cs, sclk and di are synchronous to clk and each level lasts at least one clk.
module mw_ctrl
    import mw_pkg::*;
#(
    parameter int WORDS = 64,
    parameter int DW    = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs,
    input  logic                   sclk,
    input  logic                   di,
    input  logic                   org,
    input  logic                   busy,
    input  logic [DW-1:0]          rd_data,
    output logic [$clog2(WORDS):0] rd_addr,
    output logic                   wr_en,
    output logic                   wr_all,
    output logic [$clog2(WORDS):0] wr_addr,
    output logic [DW-1:0]          wr_data,
    output logic                   dout,
    output logic                   dout_oe,
    output logic                   wen,
    output mw_state_e              st
);
    localparam int AW16 = $clog2(WORDS);
    localparam int AW8  = AW16 + 1;
    localparam int BW   = DW / 2;
    localparam int HW   = 2 + AW8;
    localparam int CW   = $clog2(HW + DW + 1);
    localparam int BIW  = $clog2(DW);

    mw_state_e      st_q;
    logic           sclk_prev;
    logic           rise;
    logic [HW-1:0]  hdr_q;
    logic [DW-1:0]  dsh_q;
    logic [CW-1:0]  cnt_q;
    logic [AW8-1:0] aq;
    logic [AW8-1:0] raddr_q;
    logic [BIW-1:0] bi_q;
    logic           rbit_q;
    logic           wen_q;
    logic           arm_q;
    logic           fill_q;

    logic [HW-1:0]  hnext;
    logic [DW-1:0]  dnext;
    logic [1:0]     op;
    logic [1:0]     sub;
    logic [AW8-1:0] addr_n;
    logic [CW-1:0]  hlast_cnt;
    logic [CW-1:0]  dlast_cnt;
    logic [BIW-1:0] bi_load;
    logic           hdr_last;
    logic           dat_last;
    logic           start_det;
    logic           erase_go;
    logic           write_go;
    logic           is_wipe;

    // Previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk;
    end

    // Header decode, bit counts and program requests.
    always_comb begin
        rise      = cs & sclk & ~sclk_prev;
        hnext     = {hdr_q[HW-2:0], di};
        dnext     = {dsh_q[DW-2:0], di};
        op        = org ? hnext[AW16+1:AW16] : hnext[AW8+1:AW8];
        sub       = org ? hnext[AW16-1:AW16-2] : hnext[AW8-1:AW8-2];
        addr_n    = org ? {1'b0, hnext[AW16-1:0]} : hnext[AW8-1:0];
        hlast_cnt = org ? CW'(1 + AW16) : CW'(1 + AW8);
        dlast_cnt = org ? CW'(DW - 1) : CW'(BW - 1);
        bi_load   = org ? BIW'(DW - 1) : BIW'(BW - 1);
        hdr_last  = (st_q == ST_HDR) && rise && (cnt_q == hlast_cnt);
        dat_last  = (st_q == ST_WD) && rise && (cnt_q == dlast_cnt);
        start_det = (st_q == ST_IDLE) && rise && di && !busy;
        is_wipe   = (op == OP_EXT) && (sub == EXT_WIPE);
        erase_go  = hdr_last && wen_q && ((op == OP_ERASE) || is_wipe);
        write_go  = dat_last && wen_q;
        wr_en     = erase_go | write_go;
        wr_all    = erase_go ? is_wipe : fill_q;
        wr_addr   = erase_go ? addr_n : aq;
        wr_data   = erase_go ? '1 : dnext;
    end

    // Instruction sequencer; a low select returns it to waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            hdr_q   <= '0;
            dsh_q   <= '0;
            cnt_q   <= '0;
            aq      <= '0;
            raddr_q <= '0;
            bi_q    <= '0;
            rbit_q  <= 1'b0;
            wen_q   <= 1'b0;
            fill_q  <= 1'b0;
        end else if (!cs) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_det) begin
                        st_q  <= ST_HDR;
                        cnt_q <= '0;
                        hdr_q <= '0;
                    end
                end
                ST_HDR: begin
                    if (rise) begin
                        hdr_q <= hnext;
                        cnt_q <= cnt_q + CW'(1);
                        if (hdr_last) begin
                            case (op)
                                OP_READ: begin
                                    st_q    <= ST_RD;
                                    raddr_q <= addr_n;
                                    bi_q    <= bi_load;
                                    rbit_q  <= 1'b0;
                                end
                                OP_WRITE: begin
                                    st_q   <= ST_WD;
                                    cnt_q  <= '0;
                                    dsh_q  <= '0;
                                    aq     <= addr_n;
                                    fill_q <= 1'b0;
                                end
                                OP_ERASE: st_q <= ST_DONE;
                                default: begin
                                    case (sub)
                                        EXT_OPEN: begin wen_q <= 1'b1; st_q <= ST_DONE; end
                                        EXT_LOCK: begin wen_q <= 1'b0; st_q <= ST_DONE; end
                                        EXT_WIPE: st_q <= ST_DONE;
                                        default: begin
                                            st_q   <= ST_WD;
                                            cnt_q  <= '0;
                                            dsh_q  <= '0;
                                            aq     <= addr_n;
                                            fill_q <= 1'b1;
                                        end
                                    endcase
                                end
                            endcase
                        end
                    end
                end
                ST_RD: begin
                    if (rise) begin
                        rbit_q <= rd_data[bi_q];
                        if (bi_q == '0) begin
                            bi_q    <= bi_load;
                            raddr_q <= org ? {1'b0, raddr_q[AW16-1:0] + AW16'(1)}
                                           : raddr_q + AW8'(1);
                        end else begin
                            bi_q <= bi_q - BIW'(1);
                        end
                    end
                end
                ST_WD: begin
                    if (rise) begin
                        dsh_q <= dnext;
                        cnt_q <= cnt_q + CW'(1);
                        if (dat_last) st_q <= ST_DONE;
                    end
                end
                default: st_q <= st_q;
            endcase
        end
    end

    // Status arming: select seen low during a program cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         arm_q <= 1'b0;
        else if (!cs)       arm_q <= busy;
        else if (start_det) arm_q <= 1'b0;
    end

    // Output mux: read bit or inverted busy.
    always_comb begin
        dout_oe = cs & ((st_q == ST_RD) | ((st_q == ST_IDLE) & arm_q));
        dout    = (st_q == ST_RD) ? rbit_q : ~busy;
        rd_addr = raddr_q;
        wen     = wen_q;
        st      = st_q;
    end
endmodule

// File: rtl/mw_eeprom.sv
// Top of the serial EEPROM slave model: front end, storage array and program timer.
// Assumes: org is strapped before reset is released and held.
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int WORDS       = 64,
    parameter int DW          = 16,
    parameter int PROG_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    input  logic di,
    input  logic org,
    output logic dout,
    output logic dout_oe
);
    localparam int AW8 = $clog2(WORDS) + 1;

    logic [AW8-1:0] rd_addr;
    logic [AW8-1:0] wr_addr;
    logic [DW-1:0]  rd_data;
    logic [DW-1:0]  wr_data;
    logic           wr_en;
    logic           wr_all;
    logic           busy;
    logic           wen;
    logic           prog_start;
    mw_state_e      st_w;

    assign prog_start = wr_en;

    mw_ctrl #(.WORDS(WORDS), .DW(DW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .sclk    (sclk),
        .di      (di),
        .org     (org),
        .busy    (busy),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_all  (wr_all),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dout    (dout),
        .dout_oe (dout_oe),
        .wen     (wen),
        .st      (st_w)
    );

    mw_array #(.WORDS(WORDS), .DW(DW)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .org     (org),
        .wr_en   (wr_en),
        .wr_all  (wr_all),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    mw_ptimer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (prog_start),
        .busy  (busy)
    );
endmodule

// File: rtl/mw_eeprom_chk.sv
// Property checker for mw_eeprom, attached by bind.
// Assumes: st carries the sequencer state encoding from mw_pkg.
module mw_eeprom_chk
    import mw_pkg::*;
#(
    parameter int PROG_CYCLES = 5000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs,
    input logic       dout,
    input logic       dout_oe,
    input logic       busy,
    input logic       wen,
    input logic       prog_start,
    input logic [2:0] st
);
    int unsigned run_q;

    // Length of the current busy run in clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !dout_oe);                                                   // R2
    AST_BUSY_SHOWS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && busy && st != ST_RD) |-> !dout);                         // R10
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st == ST_IDLE) |=> (st != ST_HDR));                         // R9
    AST_PROG_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> wen);                                                 // R7
    AST_PROG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> busy);                                                // R9
    AST_PROG_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == PROG_CYCLES));                             // R9
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && st == ST_DONE) |=> (st == ST_DONE));                          // R12
endmodule

bind mw_eeprom mw_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs         (cs),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .busy       (busy),
    .wen        (wen),
    .prog_start (prog_start),
    .st         (st_w)
);

// File: tb/mw_eeprom_bench.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module mw_eeprom_bench;
    localparam int PROG = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sclk = 1'b0;
    logic di = 1'b0;
    logic org = 1'b1;
    logic dout;
    logic dout_oe;

    int vec = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mw_eeprom #(.WORDS(64), .DW(16), .PROG_CYCLES(PROG)) u_mw_eeprom (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .di(di),
        .org(org), .dout(dout), .dout_oe(dout_oe)
    );

    // ---------------- reference model ----------------
    logic [15:0] mm [64];
    int  mode;          // 0 wait, 1 header, 2 read out, 3 data in, 4 finished
    bit  hq[$];
    bit  dq[$];
    bit  mwen, marm, mprev, mbit, mfill;
    int  left, ra, bix, mwa;

    function automatic int aw(); return org ? 6 : 7; endfunction
    function automatic int dl(); return org ? 16 : 8; endfunction

    function automatic int mget(int a);
        if (org) return int'(mm[a % 64]);
        return (a % 2 == 1) ? int'(mm[(a / 2) % 64] >> 8) : int'(mm[(a / 2) % 64] & 16'h00FF);
    endfunction

    task automatic mset(int a, int d);
        if (org) mm[a % 64] = d[15:0];
        else if (a % 2 == 1) mm[(a / 2) % 64][15:8] = d[7:0];
        else mm[(a / 2) % 64][7:0] = d[7:0];
    endtask

    task automatic mset_all(int d);
        for (int i = 0; i < 64; i++) mm[i] = org ? d[15:0] : {d[7:0], d[7:0]};
    endtask

    task automatic mreset();
        for (int i = 0; i < 64; i++) mm[i] = 16'hFFFF;
        mode = 0; mwen = 0; marm = 0; mprev = 0; mbit = 0; left = 0; mfill = 0;
        hq.delete(); dq.delete();
    endtask

    task automatic mstep();
        bit rise, was_busy, go;
        int opv, sub, a, d;
        rise = cs && sclk && !mprev;
        was_busy = (left > 0);
        go = 0;
        if (!cs) begin
            mode = 0;
            marm = was_busy;
        end else begin
            case (mode)
                0: if (rise && di && !was_busy) begin mode = 1; hq.delete(); marm = 0; end
                1: if (rise) begin
                    hq.push_back(di);
                    if (hq.size() == 2 + aw()) begin
                        opv = hq[0] * 2 + hq[1];
                        sub = hq[2] * 2 + hq[3];
                        a = 0;
                        for (int i = 2; i < hq.size(); i++) a = a * 2 + hq[i];
                        case (opv)
                            2: begin mode = 2; ra = a; bix = dl() - 1; mbit = 0; end
                            1: begin mode = 3; dq.delete(); mwa = a; mfill = 0; end
                            3: begin mode = 4; if (mwen) begin mset(a, 'hFFFF); go = 1; end end
                            default: begin
                                if (sub == 3) begin mwen = 1; mode = 4; end
                                else if (sub == 0) begin mwen = 0; mode = 4; end
                                else if (sub == 2) begin mode = 4; if (mwen) begin mset_all('hFFFF); go = 1; end end
                                else begin mode = 3; dq.delete(); mwa = a; mfill = 1; end
                            end
                        endcase
                    end
                end
                2: if (rise) begin
                    mbit = (mget(ra) >> bix) & 1;
                    if (bix == 0) begin bix = dl() - 1; ra = (ra + 1) % (org ? 64 : 128); end
                    else bix--;
                end
                3: if (rise) begin
                    dq.push_back(di);
                    if (dq.size() == dl()) begin
                        d = 0;
                        foreach (dq[i]) d = d * 2 + dq[i];
                        if (mwen) begin
                            if (mfill) mset_all(d); else mset(mwa, d);
                            go = 1;
                        end
                        mode = 4;
                    end
                end
                default: ;
            endcase
        end
        if (go) left = PROG;
        else if (left > 0) left--;
        mprev = sclk;
    endtask

    // Advance the model at each edge and compare the outputs just after it.
    always @(posedge clk) begin
        bit eoe, ed;
        if (!rst_n) mreset();
        else mstep();
        #1;
        eoe = cs && (mode == 2 || (mode == 0 && marm));
        ed  = (mode == 2) ? mbit : !(left > 0);
        vec++;
        if (dout_oe !== eoe || (eoe && dout !== ed)) begin
            fails++;
            $display("FAIL model R2 R5 R10 R11: oe=%b dout=%b expected oe=%b dout=%b at %0t",
                     dout_oe, dout, eoe, ed, $time);
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        vec++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic sbit(bit b);
        @(negedge clk); di = b; sclk = 1'b0;
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic sel();
        @(negedge clk); cs = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic desel();
        @(negedge clk); cs = 1'b0; sclk = 1'b0; di = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic hdr(logic [1:0] op, int a);
        sbit(1'b1); sbit(op[1]); sbit(op[0]);
        for (int i = aw() - 1; i >= 0; i--) sbit(a[i]);
    endtask

    task automatic ext(int sub);
        sel(); hdr(2'b00, sub << (aw() - 2)); desel();
    endtask

    task automatic wr_bits(int a, int d);
        hdr(2'b01, a);
        for (int i = dl() - 1; i >= 0; i--) sbit(d[i]);
    endtask

    task automatic wait_prog();
        desel();
        repeat (PROG + 10) @(negedge clk);
    endtask

    task automatic rd(int a, int nbits, output logic [31:0] v);
        v = '0;
        sel();
        hdr(2'b10, a);
        chk("R5 dummy bit", {31'd0, dout}, 32'd0);
        for (int i = 0; i < nbits; i++) begin
            sbit(1'b0);
            v = {v[30:0], dout};
        end
        desel();
    endtask

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 oe after reset", {31'd0, dout_oe}, 32'd0);
        rd(5, 16, v);
        chk("R1 R4 erased after reset", v, 32'h0000FFFF);

        // Write with the latch clear is ignored.
        sel(); wr_bits(3, 16'h1234); desel(); sel();
        chk("R7 no status when blocked", {31'd0, dout_oe}, 32'd0);
        desel();
        rd(3, 16, v);
        chk("R7 blocked write", v, 32'h0000FFFF);

        // Enable, write with idle clocks before the start bit, poll status.
        ext(3);
        sel(); sbit(1'b0); sbit(1'b0); sbit(1'b0); wr_bits(3, 16'h1234); desel();
        sel();
        chk("R10 busy enable", {31'd0, dout_oe}, 32'd1);
        chk("R10 busy value", {31'd0, dout}, 32'd0);
        repeat (PROG + 5) @(negedge clk);
        chk("R10 ready value", {31'd0, dout}, 32'd1);
        desel();
        rd(3, 32, v);
        chk("R3 R5 write and auto-increment", v, 32'h1234FFFF);

        // Wrap from the top address to the bottom.
        sel(); wr_bits(0, 16'h0001); wait_prog();
        sel(); wr_bits(63, 16'hA5C3); wait_prog();
        rd(63, 32, v);
        chk("R5 wrap", v, 32'hA5C30001);

        // Erase one word.
        sel(); hdr(2'b11, 3); wait_prog();
        rd(3, 16, v);
        chk("R7 erase", v, 32'h0000FFFF);

        // Select held high for the whole cycle, extra bits afterwards.
        sel(); wr_bits(10, 16'h0F0F);
        for (int i = 0; i < 20; i++) sbit(1'b1);
        chk("R11 R12 no status with cs high", {31'd0, dout_oe}, 32'd0);
        repeat (PROG) @(negedge clk);
        desel();
        rd(10, 32, v);
        chk("R12 extra bits ignored", v, 32'h0F0FFFFF);

        // Select low for the whole cycle.
        sel(); wr_bits(12, 16'h3333); desel();
        repeat (PROG + 10) @(negedge clk);
        sel();
        chk("R11 no status with cs low", {31'd0, dout_oe}, 32'd0);
        desel();
        rd(12, 16, v);
        chk("R9 write completes while deselected", v, 32'h00003333);

        // A read instruction sent during the busy window is ignored.
        sel(); wr_bits(13, 16'h7777); desel(); sel();
        hdr(2'b10, 13);
        chk("R9 start ignored while busy", {30'd0, dout_oe, dout}, 32'd2);
        repeat (PROG) @(negedge clk);
        chk("R10 ready after ignored start", {30'd0, dout_oe, dout}, 32'd3);
        desel();
        rd(13, 16, v);
        chk("R9 value after busy", v, 32'h00007777);

        // Aborted write.
        sel(); hdr(2'b01, 13);
        for (int i = 0; i < 5; i++) sbit(1'b0);
        desel(); sel();
        chk("R2 abort starts no cycle", {31'd0, dout_oe}, 32'd0);
        desel();
        rd(13, 16, v);
        chk("R2 abort leaves memory", v, 32'h00007777);

        // Byte organization.
        org = 1'b0;
        sel(); wr_bits(7, 8'h5A); wait_prog();
        rd(6, 16, v);
        chk("R6 byte read pair", v, 32'h0000FF5A);
        org = 1'b1;
        repeat (2) @(negedge clk);
        rd(3, 16, v);
        chk("R6 byte lands in high half", v, 32'h00005AFF);

        // Extended group.
        ext(0);
        sel(); wr_bits(20, 16'h1111); desel();
        rd(20, 16, v);
        chk("R8 disable blocks write", v, 32'h0000FFFF);
        ext(3);
        sel(); hdr(2'b00, 2 << 4); wait_prog();
        rd(0, 16, v);
        chk("R8 bulk erase", v, 32'h0000FFFF);
        sel(); hdr(2'b00, 1 << 4);
        for (int i = 15; i >= 0; i--) sbit(16'hBEEF >> i);
        wait_prog();
        rd(40, 32, v);
        chk("R8 bulk write", v, 32'hBEEFBEEF);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
            $finish;
        end
    end
endmodule